// File: doc/BRIEF.md
# Machine-Mode Trap and CSR Unit

This block holds the machine-mode control and status registers of a small RISC-style core and sequences trap entry and trap return. The execute stage reads, writes or swaps a register through a single access port. The pipeline signals a synchronous exception with a cause code and the faulting PC, and signals a return-from-trap with a one-cycle strobe. The block answers each of these in the same cycle with a fetch redirect, and commits the state change at the next clock edge.

Privilege and interrupt enable are not a single mode bit. They form a four-deep stack of (privilege, enable) pairs inside the status register. A trap pushes a machine-mode, interrupts-off entry onto the bottom of the stack. A return pops it and refills the top with user mode, interrupts on. The bottom level is the current mode. An access to an address that is not implemented becomes an illegal-instruction trap and does not touch any state.

Top module: `trap_csr_unit`

## Requirements
- R1: After reset the status register reads 0x003, so level 0 is machine privilege (3) with enable 0 and levels 1 to 3 are zero. The exception PC, cause and scratch registers read zero, cur_priv is 3 and cur_ie is 0.
- R2: On a trap, the cycle after trap_valid the exception PC register (address 0x341) holds trap_pc and the cause register (0x342) holds trap_cause. A system call uses cause 8.
- R3: Status (0x300) packs level i in bits [3i+2:3i], with privilege in the low two bits and enable in the top bit. A trap shifts every level up by one and drops level 3. It then loads level 0 with 3'b011 (machine, disabled).
- R4: A trap asserts redirect_valid in the same cycle with redirect_pc = 0x100 + 0x40 × (current level-0 privilege). This gives 0x100 from user mode and 0x1C0 from machine mode.
- R5: An eret asserts redirect_valid with redirect_pc equal to the exception PC register. At the next edge the stack shifts down by one level and level 3 becomes 3'b100 (user, enabled).
- R6: Any access returns the old register value on csr_rdata in the same cycle. With csr_we set, the new value is in place at the next edge, so a single access performs an atomic swap. This is shown on the scratch register (0x340).
- R7: Software can write the exception PC and cause registers, and a later eret redirects to the rewritten exception PC.
- R8: When a trap and a CSR write to the exception PC or cause register occur in the same cycle, the trap values are stored.
- R9: An access (csr_en) to any other address reads zero and writes nothing. It raises a trap with cause 2 and exception PC csr_pc, taking the R3 and R4 behaviour.
- R10: A status write stores only bits [11:0]. Bits above 11 always read zero.
- R11: The status update priority is trap first, then eret, then CSR write. A trap and an eret in the same cycle redirect to the trap vector and push the stack, and an eret beats a same-cycle status write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csr_en | input | 1 | CSR access valid |
| csr_we | input | 1 | Access writes csr_wdata (swap) |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | XLEN | Value to write |
| csr_pc | input | XLEN | PC of the accessing instruction |
| csr_rdata | output | XLEN | Old register value |
| trap_valid | input | 1 | Exception taken this cycle |
| trap_cause | input | XLEN | Cause code of the exception |
| trap_pc | input | XLEN | PC of the faulting instruction |
| eret | input | 1 | Return-from-trap strobe |
| redirect_valid | output | 1 | Fetch redirect this cycle |
| redirect_pc | output | XLEN | Redirect target |
| cur_priv | output | 2 | Current privilege (level 0) |
| cur_ie | output | 1 | Current interrupt enable (level 0) |

## Verification
The assertions assume that trap_valid, eret and csr_en are sampled as one-cycle pulses aligned to the clock. They also assume that any mix of these may coincide, and the priority rules cover that case. They expect inputs to be free of X only while the matching strobe is high. The stimulus drives every input on the falling edge, returns the strobes to zero between steps, and holds data inputs at zero when idle. The coincidences are created deliberately as directed cases after the vector walk.

// File: rtl/trap_csr_pkg.sv
// Shared constants, indices and stack helpers for the trap and CSR unit.
// Assumes a four-level privilege/enable stack of three bits per level.
package trap_csr_pkg;
    localparam int LEVELS   = 4;
    localparam int LVL_W    = 3;
    localparam int STACK_W  = LEVELS * LVL_W;
    localparam int ADDR_W   = 12;
    localparam int NUM_CSR  = 4;

    // Register indices inside the address map
    localparam int IDX_STATUS  = 0;
    localparam int IDX_SCRATCH = 1;
    localparam int IDX_EPC     = 2;
    localparam int IDX_CAUSE   = 3;

    localparam logic [1:0] PRIV_USER = 2'd0;
    localparam logic [1:0] PRIV_MACH = 2'd3;

    // One level: {enable, privilege}
    localparam logic [LVL_W-1:0] LVL_MACH_OFF = {1'b0, PRIV_MACH};
    localparam logic [LVL_W-1:0] LVL_USER_ON  = {1'b1, PRIV_USER};

    localparam logic [STACK_W-1:0] STACK_RESET = {{(STACK_W-LVL_W){1'b0}}, LVL_MACH_OFF};

    localparam int CAUSE_ILLEGAL = 2;
endpackage

// File: rtl/csr_decode.sv
// Address decoder: compares the access address against the packed
// address map and flags whether it names an implemented register.
// Assumes map entries are distinct.
module csr_decode
    import trap_csr_pkg::*;
#(
    parameter logic [NUM_CSR*ADDR_W-1:0] ADDR_MAP = {12'h342, 12'h341, 12'h340, 12'h300}
) (
    input  logic [ADDR_W-1:0]  addr,
    output logic [NUM_CSR-1:0] hit,
    output logic               legal
);
    // One comparator per implemented register
    for (genvar i = 0; i < NUM_CSR; i++) begin : g_cmp
        assign hit[i] = (addr == ADDR_MAP[i*ADDR_W +: ADDR_W]);
    end

    // Any match makes the access legal
    assign legal = |hit;
endmodule

// File: rtl/priv_stack.sv
// Privilege/enable stack held in the status register. Push on trap,
// pop on return, otherwise software write. Priority push > pop > write.
// Assumes level 0 sits in the least significant bits.
module priv_stack
    import trap_csr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               push,
    input  logic               pop,
    input  logic               wr_en,
    input  logic [STACK_W-1:0] wr_data,
    output logic [STACK_W-1:0] stack_q
);
    logic [STACK_W-1:0] pushed;
    logic [STACK_W-1:0] popped;

    // Per-level neighbour selection for shift up and shift down
    for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
        if (g == 0) begin : g_bot
            assign pushed[g*LVL_W +: LVL_W] = LVL_MACH_OFF;
        end else begin : g_up
            assign pushed[g*LVL_W +: LVL_W] = stack_q[(g-1)*LVL_W +: LVL_W];
        end
        if (g == LEVELS-1) begin : g_top
            assign popped[g*LVL_W +: LVL_W] = LVL_USER_ON;
        end else begin : g_dn
            assign popped[g*LVL_W +: LVL_W] = stack_q[(g+1)*LVL_W +: LVL_W];
        end
    end

    // Status register update in priority order
    always_ff @(posedge clk) begin
        if (!rst_n)      stack_q <= STACK_RESET;
        else if (push)   stack_q <= pushed;
        else if (pop)    stack_q <= popped;
        else if (wr_en)  stack_q <= wr_data;
    end
endmodule

// File: rtl/csr_word_reg.sv
// Full-width CSR with a trap load port that overrides a software write.
// Assumes the trap load and write strobes are single-cycle.
module csr_word_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         trap_ld,
    input  logic [W-1:0] trap_data,
    output logic [W-1:0] q
);
    // Register update, trap first
    always_ff @(posedge clk) begin
        if (!rst_n)       q <= '0;
        else if (trap_ld) q <= trap_data;
        else if (wr_en)   q <= wr_data;
    end
endmodule

// File: rtl/trap_csr_unit.sv
// Machine-mode trap and CSR unit. Decodes CSR accesses, sequences trap
// entry and return, and drives the fetch redirect combinationally.
// Assumes strobes are one-cycle pulses. An external trap outranks an
// illegal-access trap raised in the same cycle.
module trap_csr_unit
    import trap_csr_pkg::*;
#(
    parameter int          XLEN         = 32,
    parameter logic [11:0] ADDR_STATUS  = 12'h300,
    parameter logic [11:0] ADDR_SCRATCH = 12'h340,
    parameter logic [11:0] ADDR_EPC     = 12'h341,
    parameter logic [11:0] ADDR_CAUSE   = 12'h342,
    parameter int          HANDLER_BASE = 'h100,
    parameter int          VEC_STRIDE   = 'h40
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            csr_en,
    input  logic            csr_we,
    input  logic [11:0]     csr_addr,
    input  logic [XLEN-1:0] csr_wdata,
    input  logic [XLEN-1:0] csr_pc,
    output logic [XLEN-1:0] csr_rdata,
    input  logic            trap_valid,
    input  logic [XLEN-1:0] trap_cause,
    input  logic [XLEN-1:0] trap_pc,
    input  logic            eret,
    output logic            redirect_valid,
    output logic [XLEN-1:0] redirect_pc,
    output logic [1:0]      cur_priv,
    output logic            cur_ie
);
    localparam logic [NUM_CSR*ADDR_W-1:0] MAP =
        {ADDR_CAUSE, ADDR_EPC, ADDR_SCRATCH, ADDR_STATUS};

    logic [NUM_CSR-1:0] hit;
    logic               legal;
    logic               illegal_acc;
    logic               take_trap;
    logic               wr_ok;
    logic [XLEN-1:0]    sel_trap_pc;
    logic [XLEN-1:0]    sel_trap_cause;
    logic [XLEN-1:0]    vector_pc;
    logic [STACK_W-1:0] status_q;
    logic [XLEN-1:0]    scratch_q;
    logic [XLEN-1:0]    epc_q;
    logic [XLEN-1:0]    cause_q;

    csr_decode #(.ADDR_MAP(MAP)) u_dec (
        .addr  (csr_addr),
        .hit   (hit),
        .legal (legal)
    );

    // Trap source selection: external trap outranks illegal access
    assign illegal_acc    = csr_en & ~legal;
    assign take_trap      = trap_valid | illegal_acc;
    assign wr_ok          = csr_en & csr_we & legal;
    assign sel_trap_pc    = trap_valid ? trap_pc : csr_pc;
    assign sel_trap_cause = trap_valid ? trap_cause : XLEN'(CAUSE_ILLEGAL);

    priv_stack u_stack (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (take_trap),
        .pop     (eret),
        .wr_en   (wr_ok & hit[IDX_STATUS]),
        .wr_data (csr_wdata[STACK_W-1:0]),
        .stack_q (status_q)
    );

    csr_word_reg #(.W(XLEN)) u_scratch (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_ok & hit[IDX_SCRATCH]),
        .wr_data   (csr_wdata),
        .trap_ld   (1'b0),
        .trap_data ('0),
        .q         (scratch_q)
    );

    csr_word_reg #(.W(XLEN)) u_epc (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_ok & hit[IDX_EPC]),
        .wr_data   (csr_wdata),
        .trap_ld   (take_trap),
        .trap_data (sel_trap_pc),
        .q         (epc_q)
    );

    csr_word_reg #(.W(XLEN)) u_cause (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_ok & hit[IDX_CAUSE]),
        .wr_data   (csr_wdata),
        .trap_ld   (take_trap),
        .trap_data (sel_trap_cause),
        .q         (cause_q)
    );

    // Current mode is the bottom stack level
    assign cur_priv = status_q[1:0];
    assign cur_ie   = status_q[2];

    // Handler entry depends on the mode the trap is taken from
    assign vector_pc = XLEN'(HANDLER_BASE) + XLEN'(cur_priv) * XLEN'(VEC_STRIDE);

    // Redirect: trap vector beats return target
    assign redirect_valid = take_trap | eret;
    assign redirect_pc    = take_trap ? vector_pc : epc_q;

    // Read mux returning the pre-write value
    always_comb begin
        csr_rdata = '0;
        if (csr_en) begin
            unique case (1'b1)
                hit[IDX_STATUS]:  csr_rdata = XLEN'(status_q);
                hit[IDX_SCRATCH]: csr_rdata = scratch_q;
                hit[IDX_EPC]:     csr_rdata = epc_q;
                hit[IDX_CAUSE]:   csr_rdata = cause_q;
                default:          csr_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/trap_csr_unit_chk.sv
// Property checker for trap_csr_unit, bound to every instance.
// Assumes strobes are one-cycle pulses and a synchronous active-low reset.
module trap_csr_unit_chk #(
    parameter int XLEN         = 32,
    parameter int HANDLER_BASE = 'h100
) (
    input logic            clk,
    input logic            rst_n,
    input logic            trap_valid,
    input logic [XLEN-1:0] trap_pc,
    input logic [XLEN-1:0] trap_cause,
    input logic            eret,
    input logic            illegal_acc,
    input logic [11:0]     status_q,
    input logic [XLEN-1:0] epc_q,
    input logic [XLEN-1:0] cause_q,
    input logic [XLEN-1:0] scratch_q,
    input logic            redirect_valid,
    input logic [XLEN-1:0] redirect_pc,
    input logic [1:0]      cur_priv
);
    AST_TRAP_EPC: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |=> epc_q == $past(trap_pc)); // R2
    AST_TRAP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |=> cause_q == $past(trap_cause)); // R2
    AST_STACK_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid || illegal_acc) |=> status_q == {$past(status_q[8:0]), 3'b011}); // R3
    AST_STACK_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (eret && !trap_valid && !illegal_acc) |=> status_q == {3'b100, $past(status_q[11:3])}); // R5
    AST_USER_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid && cur_priv == 2'd0) |-> redirect_pc == XLEN'(HANDLER_BASE)); // R4
    AST_REDIRECT_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid || eret || illegal_acc) |-> redirect_valid); // R4
    AST_ERET_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (eret && !trap_valid && !illegal_acc) |-> redirect_pc == epc_q); // R5
    AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (illegal_acc && !trap_valid) |=> scratch_q == $past(scratch_q)); // R9
endmodule

bind trap_csr_unit trap_csr_unit_chk #(.XLEN(XLEN), .HANDLER_BASE(HANDLER_BASE)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .trap_valid     (trap_valid),
    .trap_pc        (trap_pc),
    .trap_cause     (trap_cause),
    .eret           (eret),
    .illegal_acc    (illegal_acc),
    .status_q       (status_q),
    .epc_q          (epc_q),
    .cause_q        (cause_q),
    .scratch_q      (scratch_q),
    .redirect_valid (redirect_valid),
    .redirect_pc    (redirect_pc),
    .cur_priv       (cur_priv)
);

// File: tb/tb_trap_csr_unit.sv
`timescale 1ns/1ps
module tb_trap_csr_unit;
    localparam int XLEN = 32;
    localparam logic [1:0] K_RD = 2'd0, K_WR = 2'd1, K_TRAP = 2'd2, K_RET = 2'd3;

    typedef struct packed {
        logic [1:0]  kind;
        logic [11:0] addr;
        logic [31:0] data;
        logic [31:0] pc;
        logic [31:0] exp;
    } vec_t;

    // Expected: rdata for legal access, redirect_pc for trap/eret/illegal
    localparam vec_t VEC [20] = '{
        '{K_RD,   12'h300, 32'h0,         32'h0,    32'h003},       // R1 status reset
        '{K_WR,   12'h340, 32'hA5A5_0001, 32'h0,    32'h0},         // R6 old scratch
        '{K_WR,   12'h340, 32'h0000_1234, 32'h0,    32'hA5A5_0001}, // R6 swap
        '{K_RD,   12'h340, 32'h0,         32'h0,    32'h0000_1234}, // R6
        '{K_WR,   12'h300, 32'h0000_F1C4, 32'h0,    32'h003},       // R10
        '{K_RD,   12'h300, 32'h0,         32'h0,    32'h1C4},       // R10 upper dropped
        '{K_TRAP, 12'h000, 32'd8,         32'h2000, 32'h100},       // R4 user vector
        '{K_RD,   12'h341, 32'h0,         32'h0,    32'h2000},      // R2 epc
        '{K_RD,   12'h342, 32'h0,         32'h0,    32'd8},         // R2 cause
        '{K_RD,   12'h300, 32'h0,         32'h0,    32'hE23},       // R3 push
        '{K_WR,   12'h341, 32'h2004,      32'h0,    32'h2000},      // R7 rewrite epc
        '{K_RET,  12'h000, 32'h0,         32'h0,    32'h2004},      // R7 R5 return target
        '{K_RD,   12'h300, 32'h0,         32'h0,    32'h9C4},       // R5 pop
        '{K_TRAP, 12'h000, 32'd2,         32'h3000, 32'h100},       // R4 from user
        '{K_TRAP, 12'h000, 32'd8,         32'h3010, 32'h1C0},       // R4 from machine
        '{K_RD,   12'h300, 32'h0,         32'h0,    32'h11B},       // R3 second push
        '{K_RD,   12'h341, 32'h0,         32'h0,    32'h3010},      // R2
        '{K_RD,   12'h7FF, 32'h0,         32'h4000, 32'h1C0},       // R9 illegal read
        '{K_RD,   12'h342, 32'h0,         32'h0,    32'd2},         // R9 cause 2
        '{K_RD,   12'h341, 32'h0,         32'h0,    32'h4000}       // R9 epc
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            csr_en = 1'b0, csr_we = 1'b0;
    logic [11:0]     csr_addr = '0;
    logic [XLEN-1:0] csr_wdata = '0, csr_pc = '0;
    logic [XLEN-1:0] csr_rdata;
    logic            trap_valid = 1'b0;
    logic [XLEN-1:0] trap_cause = '0, trap_pc = '0;
    logic            eret = 1'b0;
    logic            redirect_valid;
    logic [XLEN-1:0] redirect_pc;
    logic [1:0]      cur_priv;
    logic            cur_ie;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    trap_csr_unit dut (
        .clk(clk), .rst_n(rst_n),
        .csr_en(csr_en), .csr_we(csr_we), .csr_addr(csr_addr),
        .csr_wdata(csr_wdata), .csr_pc(csr_pc), .csr_rdata(csr_rdata),
        .trap_valid(trap_valid), .trap_cause(trap_cause), .trap_pc(trap_pc),
        .eret(eret), .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
        .cur_priv(cur_priv), .cur_ie(cur_ie)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        csr_en = 0; csr_we = 0; csr_addr = '0; csr_wdata = '0; csr_pc = '0;
        trap_valid = 0; trap_cause = '0; trap_pc = '0; eret = 0;
    endtask

    // Finish a step: let the edge commit, then return strobes low
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string req);
        csr_en = 1; csr_addr = a; #1;
        chk(req, csr_rdata, exp);
        tick();
    endtask

    function automatic bit is_legal(input logic [11:0] a);
        return a == 12'h300 || a == 12'h340 || a == 12'h341 || a == 12'h342;
    endfunction

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1;
        chk("R1 priv", 32'(cur_priv), 32'd3);
        chk("R1 ie", 32'(cur_ie), 32'd0);

        // Vector walk
        for (int i = 0; i < 20; i++) begin
            case (VEC[i].kind)
                K_RD, K_WR: begin
                    csr_en = 1; csr_we = (VEC[i].kind == K_WR);
                    csr_addr = VEC[i].addr; csr_wdata = VEC[i].data; csr_pc = VEC[i].pc;
                    #1;
                    if (is_legal(VEC[i].addr)) chk($sformatf("R6 R10 vec%0d", i), csr_rdata, VEC[i].exp);
                    else chk($sformatf("R9 vec%0d", i), redirect_pc, VEC[i].exp);
                end
                K_TRAP: begin
                    trap_valid = 1; trap_cause = VEC[i].data; trap_pc = VEC[i].pc; #1;
                    chk($sformatf("R4 vec%0d", i), redirect_pc, VEC[i].exp);
                    chk($sformatf("R4 valid vec%0d", i), 32'(redirect_valid), 32'd1);
                end
                default: begin
                    eret = 1; #1;
                    chk($sformatf("R5 vec%0d", i), redirect_pc, VEC[i].exp);
                end
            endcase
            tick();
        end

        // R8: trap and EPC write collide, trap wins
        csr_en = 1; csr_we = 1; csr_addr = 12'h341; csr_wdata = 32'h5555;
        trap_valid = 1; trap_cause = 32'd8; trap_pc = 32'h6000; #1;
        chk("R8 redirect", redirect_pc, 32'h1C0);
        tick();
        rd(12'h341, 32'h6000, "R8 epc");
        rd(12'h342, 32'd8, "R8 cause");
        rd(12'h300, 32'h6DB, "R3 status");

        // R11: trap and eret together
        trap_valid = 1; trap_cause = 32'd2; trap_pc = 32'h7000; eret = 1; #1;
        chk("R11 redirect", redirect_pc, 32'h1C0);
        tick();
        rd(12'h300, 32'h6DB, "R11 pushed not popped");

        // R9: illegal write leaves scratch alone
        csr_en = 1; csr_we = 1; csr_addr = 12'h7FF; csr_wdata = 32'hDEAD; csr_pc = 32'h8000; #1;
        chk("R9 rdata zero", csr_rdata, 32'h0);
        chk("R9 redirect valid", 32'(redirect_valid), 32'd1);
        tick();
        rd(12'h340, 32'h1234, "R9 scratch kept");
        rd(12'h300, 32'h6DB, "R9 status pushed");

        // R11: eret beats same-cycle status write
        csr_en = 1; csr_we = 1; csr_addr = 12'h300; csr_wdata = 32'h0; eret = 1; #1;
        chk("R5 return target", redirect_pc, 32'h8000);
        tick();
        rd(12'h300, 32'h8DB, "R11 pop over write");
        chk("R5 priv", 32'(cur_priv), 32'd3);

        // R1: reset again
        rst_n = 0;
        @(posedge clk); @(negedge clk);
        rst_n = 1;
        rd(12'h300, 32'h003, "R1 status");
        rd(12'h341, 32'h0, "R1 epc");
        rd(12'h342, 32'h0, "R1 cause");
        rd(12'h340, 32'h0, "R1 scratch");
        chk("R1 ie", 32'(cur_ie), 32'd0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule